// File: doc/BRIEF.md
# General-Purpose I/O Port with Atomic Set/Clear and Level Sensing

This block is a 32-pin general-purpose I/O port controlled through a simple register bus with single-cycle access. Software drives pin levels through an output data register and chooses each pin's direction through a port-wide direction register. Each pin also has its own configuration word, which selects input-buffer connection, pull resistor, drive code and level-sense condition. Separate set and clear addresses change the output and direction registers bit by bit, so no read-modify-write is needed. A pin's direction bit is held in one place only, and both the port-wide register and the pin's configuration word read and write that same bit.

Pad inputs pass through a two-flop synchronizer before they appear in a read-only input register. Each pin can be told to sense a high or a low level. A sense match sets a sticky bit in a latch register, and software clears that bit by writing 1 to it. A single detect output summarises the port. In one mode it follows the live sense matches. In the other mode it follows the latch register, so a short event is not lost before software services it.

Register bus rules: a write takes effect on the clock edge where `bus_wr_en` is high. A read requested with `bus_rd_en` returns its data in `bus_rdata`, with `bus_rvalid` high, on the following cycle. The bus never stalls, so there is no back-pressure.

Top module: `pio_port`

## Requirements
- R1: A write to offset 0x504 loads the output register. The output register drives `pad_out` and reads back at 0x504.
- R2: A write to 0x508 sets every output bit that is written as 1. A write to 0x50C clears every output bit that is written as 1. Bits written as 0 keep their value in both cases.
- R3: The direction register is at 0x514, with 1 meaning output. A write to 0x518 makes the pins written as 1 outputs. A write to 0x51C makes the pins written as 1 inputs. Bits written as 0 have no effect.
- R4: Pin n's configuration word is at 0x700 + 4n. Its bit 0 is the same storage as bit n of the direction register, so a write through either address is visible through both.
- R5: In the configuration word, bit 1 set disconnects the input buffer, which drives `pad_ie` low. Bits 3:2 select the pull: 1 drives `pad_pd`, 3 drives `pad_pu`, and 0 or 2 drives neither. Bits 10:8 appear on the pin's 3-bit `pad_drive` field. Bits 17:16 hold the sense code. All other bits read as 0.
- R6: `pad_oe` is high only for an output pin, and with two exceptions. When the drive code is 6 or 7 and the output is 1, `pad_oe` is low (open drain). When the drive code is 4 or 5 and the output is 0, `pad_oe` is low.
- R7: The input register at 0x510 shows the pad inputs after two flops. A pin whose input buffer is disconnected reads 0. Writes to 0x510 are ignored.
- R8: Sense code 2 matches a high input and code 3 matches a low input. Codes 0 and 1 never match. A match sets that pin's bit in the latch register at 0x520. Writing 1 to a latch bit clears it, unless the match is still present. Writing 0 has no effect.
- R9: Bit 0 at 0x524 selects the detect mode. With 0, `detect` is the OR of the live sense matches. With 1, `detect` is the OR of the latch bits.
- R10: `bus_rvalid` is high exactly in the cycle after `bus_rd_en`. Reads of unmapped addresses, including configuration slots past the last pin, return 0. Writes to unmapped addresses change nothing.
- R11: After reset, all registers are 0. All pins are inputs with the input buffer connected, no pull and no output enable, and `detect` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_wr_en | input | 1 | Register write strobe |
| bus_rd_en | input | 1 | Register read request |
| bus_addr | input | 12 | Byte address of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid with bus_rvalid |
| bus_rvalid | output | 1 | Read data valid, one cycle after the request |
| pad_in | input | NUM_PINS | Raw pad input levels |
| pad_out | output | NUM_PINS | Output data to pads |
| pad_oe | output | NUM_PINS | Per-pin output driver enable |
| pad_ie | output | NUM_PINS | Per-pin input buffer enable |
| pad_pu | output | NUM_PINS | Per-pin pull-up enable |
| pad_pd | output | NUM_PINS | Per-pin pull-down enable |
| pad_drive | output | 3*NUM_PINS | Per-pin drive code, 3 bits per pin |
| detect | output | 1 | Combined sense detect |

## Verification
The bench builds the port with its default of 32 pins. With that setting, every data bit of a bus word maps to a pin. The configuration window runs from 0x700 to 0x77C, and the first slot past it, 0x780, falls in unmapped space and must read back as zero. The two-flop input latency is measured by reading the input register one and two cycles after a pad change. The latch and the detect mode are exercised with high and low sense codes, the disabled sense code, short events and persistent events, including a clear attempted while the sense condition still holds.

// File: rtl/pio_pkg.sv
package pio_pkg;
  localparam int BUS_W  = 32;
  localparam int ADDR_W = 12;

  localparam logic [ADDR_W-1:0] OFS_OUT    = 12'h504;
  localparam logic [ADDR_W-1:0] OFS_OUTSET = 12'h508;
  localparam logic [ADDR_W-1:0] OFS_OUTCLR = 12'h50C;
  localparam logic [ADDR_W-1:0] OFS_IN     = 12'h510;
  localparam logic [ADDR_W-1:0] OFS_DIR    = 12'h514;
  localparam logic [ADDR_W-1:0] OFS_DIRSET = 12'h518;
  localparam logic [ADDR_W-1:0] OFS_DIRCLR = 12'h51C;
  localparam logic [ADDR_W-1:0] OFS_LATCH  = 12'h520;
  localparam logic [ADDR_W-1:0] OFS_DMODE  = 12'h524;
  localparam logic [ADDR_W-1:0] OFS_CFG0   = 12'h700;

  typedef enum logic [1:0] {
    SNS_NONE = 2'd0, SNS_RSVD = 2'd1, SNS_HIGH = 2'd2, SNS_LOW = 2'd3
  } sense_e;

  typedef enum logic [1:0] {
    PULL_NONE = 2'd0, PULL_DOWN = 2'd1, PULL_RSVD = 2'd2, PULL_UP = 2'd3
  } pull_e;

  typedef struct packed {
    sense_e     sense;
    logic [2:0] drive;
    pull_e      pull;
    logic       in_off;
  } pin_cfg_t;

  typedef struct packed {
    logic out_w;
    logic outset;
    logic outclr;
    logic in_r;
    logic dir_w;
    logic dirset;
    logic dirclr;
    logic latch;
    logic dmode;
    logic cfg;
  } reg_hit_t;

  function automatic logic [BUS_W-1:0] cfg_to_word(logic dir, pin_cfg_t c);
    logic [BUS_W-1:0] w;
    w        = '0;
    w[0]     = dir;
    w[1]     = c.in_off;
    w[3:2]   = c.pull;
    w[10:8]  = c.drive;
    w[17:16] = c.sense;
    return w;
  endfunction

  function automatic pin_cfg_t word_to_cfg(logic [BUS_W-1:0] w);
    pin_cfg_t c;
    c.in_off = w[1];
    c.pull   = pull_e'(w[3:2]);
    c.drive  = w[10:8];
    c.sense  = sense_e'(w[17:16]);
    return c;
  endfunction

  function automatic logic hi_side_off(logic [2:0] d);
    return (d == 3'd6) || (d == 3'd7);
  endfunction

  function automatic logic lo_side_off(logic [2:0] d);
    return (d == 3'd4) || (d == 3'd5);
  endfunction
endpackage

// File: rtl/pio_sync.sv
module pio_sync #(
  parameter int WIDTH = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d_async,
  output logic [WIDTH-1:0] q_sync
);
  logic [WIDTH-1:0] stage1_q;
  logic [WIDTH-1:0] stage2_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage1_q <= '0;
      stage2_q <= '0;
    end else begin
      stage1_q <= d_async;
      stage2_q <= stage1_q;
    end
  end

  assign q_sync = stage2_q;
endmodule

// File: rtl/pio_addr_dec.sv
module pio_addr_dec
  import pio_pkg::*;
#(
  parameter int NUM_PINS = 32,
  parameter int IDX_W    = $clog2(NUM_PINS)
) (
  input  logic [ADDR_W-1:0] addr,
  output reg_hit_t          hit,
  output logic [IDX_W-1:0]  cfg_idx
);
  localparam logic [ADDR_W-1:0] CFG_SPAN = ADDR_W'(4 * NUM_PINS);

  logic [ADDR_W-1:0] rel;

  assign rel     = addr - OFS_CFG0;
  assign cfg_idx = rel[IDX_W+1:2];

  always_comb begin
    hit        = '0;
    hit.out_w  = (addr == OFS_OUT);
    hit.outset = (addr == OFS_OUTSET);
    hit.outclr = (addr == OFS_OUTCLR);
    hit.in_r   = (addr == OFS_IN);
    hit.dir_w  = (addr == OFS_DIR);
    hit.dirset = (addr == OFS_DIRSET);
    hit.dirclr = (addr == OFS_DIRCLR);
    hit.latch  = (addr == OFS_LATCH);
    hit.dmode  = (addr == OFS_DMODE);
    // unsigned wrap makes addresses below the window compare large
    hit.cfg    = (rel[1:0] == 2'b00) && (rel < CFG_SPAN);
  end
endmodule

// File: rtl/pio_pin_cell.sv
module pio_pin_cell
  import pio_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       dir_wr,
  input  logic       dir_wval,
  input  logic       dir_set,
  input  logic       dir_clr,
  input  logic       cfg_wr,
  input  logic       cfg_dir,
  input  pin_cfg_t   cfg_in,
  input  logic       out_bit,
  input  logic       in_sync,
  output logic       dir_q,
  output pin_cfg_t   cfg_q,
  output logic       pad_oe,
  output logic       pad_ie,
  output logic       pad_pu,
  output logic       pad_pd,
  output logic [2:0] pad_drv,
  output logic       in_val,
  output logic       sense_hit
);
  // single storage bit for direction, reachable from two address views
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dir_q <= 1'b0;
    end else if (cfg_wr) begin
      dir_q <= cfg_dir;
    end else if (dir_wr) begin
      dir_q <= dir_wval;
    end else if (dir_set) begin
      dir_q <= 1'b1;
    end else if (dir_clr) begin
      dir_q <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q <= '0;
    end else if (cfg_wr) begin
      cfg_q <= cfg_in;
    end
  end

  logic drv_allowed;
  always_comb begin
    if (out_bit) drv_allowed = !hi_side_off(cfg_q.drive);
    else         drv_allowed = !lo_side_off(cfg_q.drive);
  end

  assign pad_oe  = dir_q & drv_allowed;
  assign pad_ie  = ~cfg_q.in_off;
  assign pad_pu  = (cfg_q.pull == PULL_UP);
  assign pad_pd  = (cfg_q.pull == PULL_DOWN);
  assign pad_drv = cfg_q.drive;

  assign in_val = in_sync & ~cfg_q.in_off;

  always_comb begin
    unique case (cfg_q.sense)
      SNS_HIGH: sense_hit = in_val;
      SNS_LOW:  sense_hit = ~in_val;
      default:  sense_hit = 1'b0;
    endcase
  end
endmodule

// File: rtl/pio_detect.sv
module pio_detect #(
  parameter int NUM_PINS = 32
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [NUM_PINS-1:0] sense_hit,
  input  logic                clr_we,
  input  logic [NUM_PINS-1:0] clr_mask,
  input  logic                mode_we,
  input  logic                mode_wval,
  output logic [NUM_PINS-1:0] latch_q,
  output logic                dmode_q,
  output logic                detect
);
  logic [NUM_PINS-1:0] clr_eff;
  assign clr_eff = clr_we ? clr_mask : '0;

  // set dominates clear so a persisting condition cannot be wiped
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      latch_q <= '0;
      dmode_q <= 1'b0;
    end else begin
      latch_q <= (latch_q & ~clr_eff) | sense_hit;
      if (mode_we) dmode_q <= mode_wval;
    end
  end

  assign detect = dmode_q ? (|latch_q) : (|sense_hit);
endmodule

// File: rtl/pio_port.sv
module pio_port
  import pio_pkg::*;
#(
  parameter int NUM_PINS = 32
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  bus_wr_en,
  input  logic                  bus_rd_en,
  input  logic [ADDR_W-1:0]     bus_addr,
  input  logic [BUS_W-1:0]      bus_wdata,
  output logic [BUS_W-1:0]      bus_rdata,
  output logic                  bus_rvalid,
  input  logic [NUM_PINS-1:0]   pad_in,
  output logic [NUM_PINS-1:0]   pad_out,
  output logic [NUM_PINS-1:0]   pad_oe,
  output logic [NUM_PINS-1:0]   pad_ie,
  output logic [NUM_PINS-1:0]   pad_pu,
  output logic [NUM_PINS-1:0]   pad_pd,
  output logic [3*NUM_PINS-1:0] pad_drive,
  output logic                  detect
);
  localparam int IDX_W = $clog2(NUM_PINS);

  reg_hit_t            hit;
  reg_hit_t            we;
  logic [IDX_W-1:0]    cfg_idx;
  logic [NUM_PINS-1:0] wmask;
  logic [NUM_PINS-1:0] out_q;
  logic [NUM_PINS-1:0] in_sync;
  logic [NUM_PINS-1:0] in_vec;
  logic [NUM_PINS-1:0] dir_vec;
  logic [NUM_PINS-1:0] hit_vec;
  logic [NUM_PINS-1:0] latch_vec;
  logic                dmode_q;
  logic [BUS_W-1:0]    cfg_rd [NUM_PINS];
  logic                cfg_dir_w;
  pin_cfg_t            cfg_w;

  pio_addr_dec #(.NUM_PINS(NUM_PINS), .IDX_W(IDX_W)) u_dec (
    .addr    (bus_addr),
    .hit     (hit),
    .cfg_idx (cfg_idx)
  );

  assign we        = bus_wr_en ? hit : '0;
  assign wmask     = bus_wdata[NUM_PINS-1:0];
  assign cfg_dir_w = bus_wdata[0];
  assign cfg_w     = word_to_cfg(bus_wdata);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_q <= '0;
    end else if (we.out_w) begin
      out_q <= wmask;
    end else if (we.outset) begin
      out_q <= out_q | wmask;
    end else if (we.outclr) begin
      out_q <= out_q & ~wmask;
    end
  end

  assign pad_out = out_q;

  pio_sync #(.WIDTH(NUM_PINS)) u_sync (
    .clk     (clk),
    .rst_n   (rst_n),
    .d_async (pad_in),
    .q_sync  (in_sync)
  );

  for (genvar i = 0; i < NUM_PINS; i++) begin : g_pin
    pin_cfg_t cfg_q_i;
    logic     cfg_wr_i;
    assign cfg_wr_i = we.cfg && (cfg_idx == IDX_W'(i));

    pio_pin_cell u_cell (
      .clk       (clk),
      .rst_n     (rst_n),
      .dir_wr    (we.dir_w),
      .dir_wval  (wmask[i]),
      .dir_set   (we.dirset & wmask[i]),
      .dir_clr   (we.dirclr & wmask[i]),
      .cfg_wr    (cfg_wr_i),
      .cfg_dir   (cfg_dir_w),
      .cfg_in    (cfg_w),
      .out_bit   (out_q[i]),
      .in_sync   (in_sync[i]),
      .dir_q     (dir_vec[i]),
      .cfg_q     (cfg_q_i),
      .pad_oe    (pad_oe[i]),
      .pad_ie    (pad_ie[i]),
      .pad_pu    (pad_pu[i]),
      .pad_pd    (pad_pd[i]),
      .pad_drv   (pad_drive[3*i +: 3]),
      .in_val    (in_vec[i]),
      .sense_hit (hit_vec[i])
    );

    assign cfg_rd[i] = cfg_to_word(dir_vec[i], cfg_q_i);
  end

  pio_detect #(.NUM_PINS(NUM_PINS)) u_det (
    .clk       (clk),
    .rst_n     (rst_n),
    .sense_hit (hit_vec),
    .clr_we    (we.latch),
    .clr_mask  (wmask),
    .mode_we   (we.dmode),
    .mode_wval (bus_wdata[0]),
    .latch_q   (latch_vec),
    .dmode_q   (dmode_q),
    .detect    (detect)
  );

  logic [BUS_W-1:0] rd_word;
  always_comb begin
    rd_word = '0;
    if (hit.out_w)      rd_word = BUS_W'(out_q);
    else if (hit.in_r)  rd_word = BUS_W'(in_vec);
    else if (hit.dir_w) rd_word = BUS_W'(dir_vec);
    else if (hit.latch) rd_word = BUS_W'(latch_vec);
    else if (hit.dmode) rd_word = BUS_W'(dmode_q);
    else if (hit.cfg)   rd_word = cfg_rd[cfg_idx];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bus_rdata  <= '0;
      bus_rvalid <= 1'b0;
    end else begin
      bus_rvalid <= bus_rd_en;
      if (bus_rd_en) bus_rdata <= rd_word;
    end
  end
endmodule

// File: rtl/pio_port_chk.sv
module pio_port_chk
  import pio_pkg::*;
#(
  parameter int NUM_PINS = 32
) (
  input logic                clk,
  input logic                rst_n,
  input logic                bus_wr_en,
  input logic                bus_rd_en,
  input logic [ADDR_W-1:0]   bus_addr,
  input logic [BUS_W-1:0]    bus_wdata,
  input logic                bus_rvalid,
  input logic [NUM_PINS-1:0] pad_out,
  input logic [NUM_PINS-1:0] pad_oe,
  input logic [NUM_PINS-1:0] dir_q,
  input logic [NUM_PINS-1:0] latch_q,
  input logic                dmode_q,
  input logic                detect
);
  logic [NUM_PINS-1:0] wm;
  assign wm = bus_wdata[NUM_PINS-1:0];

  // R2
  outset_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr_en && bus_addr == OFS_OUTSET) |=>
      (((pad_out & $past(wm)) == $past(wm)) &&
       ((pad_out & ~$past(wm)) == ($past(pad_out) & ~$past(wm)))));

  // R2
  outclr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr_en && bus_addr == OFS_OUTCLR) |=>
      (((pad_out & $past(wm)) == '0) &&
       ((pad_out & ~$past(wm)) == ($past(pad_out) & ~$past(wm)))));

  // R3
  dirset_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr_en && bus_addr == OFS_DIRSET) |=>
      (((dir_q & $past(wm)) == $past(wm)) &&
       ((dir_q & ~$past(wm)) == ($past(dir_q) & ~$past(wm)))));

  // R3
  dirclr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr_en && bus_addr == OFS_DIRCLR) |=>
      (((dir_q & $past(wm)) == '0) &&
       ((dir_q & ~$past(wm)) == ($past(dir_q) & ~$past(wm)))));

  // R6
  oe_needs_dir_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((pad_oe & ~dir_q) == '0));

  // R8
  latch_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(bus_wr_en && bus_addr == OFS_LATCH) |=>
      ((latch_q & $past(latch_q)) == $past(latch_q)));

  // R9
  detect_latched_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dmode_q |-> (detect == (latch_q != '0)));

  // R10
  rvalid_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bus_rd_en |=> bus_rvalid);

  // R10
  rvalid_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_rd_en |=> !bus_rvalid);
endmodule

bind pio_port pio_port_chk #(.NUM_PINS(NUM_PINS)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .bus_wr_en  (bus_wr_en),
  .bus_rd_en  (bus_rd_en),
  .bus_addr   (bus_addr),
  .bus_wdata  (bus_wdata),
  .bus_rvalid (bus_rvalid),
  .pad_out    (pad_out),
  .pad_oe     (pad_oe),
  .dir_q      (dir_vec),
  .latch_q    (latch_vec),
  .dmode_q    (dmode_q),
  .detect     (detect)
);

// File: tb/tb_pio_port.sv
module tb_pio_port;
  localparam int CLK_PERIOD = 10;
  localparam int NP = 32;
  localparam int NV = 32;
  localparam logic OPW = 1'b0;
  localparam logic OPR = 1'b1;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic            bus_wr_en = 1'b0;
  logic            bus_rd_en = 1'b0;
  logic [11:0]     bus_addr = '0;
  logic [31:0]     bus_wdata = '0;
  logic [31:0]     bus_rdata;
  logic            bus_rvalid;
  logic [NP-1:0]   pad_in = '0;
  logic [NP-1:0]   pad_out, pad_oe, pad_ie, pad_pu, pad_pd;
  logic [3*NP-1:0] pad_drive;
  logic            detect;

  int n_chk = 0;
  int n_fail = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  pio_port #(.NUM_PINS(NP)) dut (
    .clk(clk), .rst_n(rst_n), .bus_wr_en(bus_wr_en), .bus_rd_en(bus_rd_en),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .bus_rvalid(bus_rvalid), .pad_in(pad_in), .pad_out(pad_out),
    .pad_oe(pad_oe), .pad_ie(pad_ie), .pad_pu(pad_pu), .pad_pd(pad_pd),
    .pad_drive(pad_drive), .detect(detect)
  );

  // {op, addr, data}; reads compare against data
  localparam logic [44:0] VEC [NV] = '{
    {OPR, 12'h504, 32'h0000_0000}, // R11
    {OPR, 12'h514, 32'h0000_0000}, // R11
    {OPR, 12'h520, 32'h0000_0000}, // R11
    {OPR, 12'h524, 32'h0000_0000}, // R11
    {OPW, 12'h504, 32'hA5A5_0F0F},
    {OPR, 12'h504, 32'hA5A5_0F0F}, // R1
    {OPW, 12'h508, 32'h0000_F0F0},
    {OPR, 12'h504, 32'hA5A5_FFFF}, // R2
    {OPW, 12'h50C, 32'hA500_0000},
    {OPR, 12'h504, 32'h00A5_FFFF}, // R2
    {OPW, 12'h518, 32'h0000_00FF},
    {OPR, 12'h514, 32'h0000_00FF}, // R3
    {OPW, 12'h51C, 32'h0000_000F},
    {OPR, 12'h514, 32'h0000_00F0}, // R3
    {OPR, 12'h700, 32'h0000_0000}, // R4
    {OPR, 12'h710, 32'h0000_0001}, // R4
    {OPW, 12'h704, 32'h0000_070D},
    {OPR, 12'h704, 32'h0000_070D}, // R5
    {OPR, 12'h514, 32'h0000_00F2}, // R4
    {OPW, 12'h514, 32'h0000_0000},
    {OPR, 12'h704, 32'h0000_070C}, // R4
    {OPW, 12'h708, 32'hFFFC_FFFF},
    {OPR, 12'h708, 32'h0000_070F}, // R5
    {OPW, 12'h510, 32'hFFFF_FFFF},
    {OPR, 12'h510, 32'h0000_0000}, // R7
    {OPW, 12'h600, 32'hFFFF_FFFF},
    {OPW, 12'h780, 32'hFFFF_FFFF},
    {OPR, 12'h600, 32'h0000_0000}, // R10
    {OPR, 12'h780, 32'h0000_0000}, // R10
    {OPR, 12'h504, 32'h00A5_FFFF}, // R10
    {OPR, 12'h514, 32'h0000_0004}, // R10
    {OPW, 12'h708, 32'h0000_0000}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic do_wr(input logic [11:0] a, input logic [31:0] d);
    bus_wr_en = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr_en = 1'b0;
  endtask

  task automatic do_rd(input logic [11:0] a, output logic [31:0] d);
    bus_rd_en = 1'b1; bus_addr = a;
    @(negedge clk);
    bus_rd_en = 1'b0;
    chk("R10 rvalid", {31'd0, bus_rvalid}, 32'd1);
    d = bus_rdata;
  endtask

  task automatic rd_chk(input string req, input logic [11:0] a, input logic [31:0] exp);
    logic [31:0] d;
    do_rd(a, d);
    chk(req, d, exp);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog actual running expected finished");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R11 reset state at the pads
    chk("R11 pad_out", pad_out, '0);
    chk("R11 pad_oe", pad_oe, '0);
    chk("R11 pad_ie", pad_ie, '1);
    chk("R11 pulls", pad_pu | pad_pd, '0);
    chk("R11 detect", {31'd0, detect}, 32'd0);
    rst_n = 1'b1;
    @(negedge clk);

    for (int i = 0; i < NV; i++) begin
      if (VEC[i][44] == OPW) do_wr(VEC[i][43:32], VEC[i][31:0]);
      else rd_chk($sformatf("vector %0d R1-R11 table", i), VEC[i][43:32], VEC[i][31:0]);
    end
    chk("R10 rvalid low when idle", {31'd0, bus_rvalid}, 32'd0);

    // R6 / R5 pad controls (out = 00A5FFFF)
    do_wr(12'h514, 32'hFFFF_FFFF);
    do_wr(12'h700, 32'h0000_0601);
    chk("R6 drive6 high open", {31'd0, pad_oe[0]}, 32'd0);
    chk("R6 normal drive oe", {31'd0, pad_oe[16]}, 32'd1);
    do_wr(12'h50C, 32'h0000_0001);
    chk("R6 drive6 low drives", {31'd0, pad_oe[0]}, 32'd1);
    do_wr(12'h704, 32'h0000_0401);
    chk("R6 drive4 high drives", {31'd0, pad_oe[1]}, 32'd1);
    chk("R5 drive field", {29'd0, pad_drive[5:3]}, 32'd4);
    do_wr(12'h50C, 32'h0000_0002);
    chk("R6 drive4 low open", {31'd0, pad_oe[1]}, 32'd0);
    do_wr(12'h708, 32'h0000_000F);
    chk("R5 pull up", {29'd0, pad_pu[2], pad_pd[2], pad_ie[2]}, 32'b100);
    do_wr(12'h70C, 32'h0000_0005);
    chk("R5 pull down", {29'd0, pad_pu[3], pad_pd[3], pad_ie[3]}, 32'b011);
    do_wr(12'h514, 32'h0000_0000);
    chk("R3 inputs no oe", pad_oe, '0);
    do_wr(12'h700, 32'h0);
    do_wr(12'h704, 32'h0);

    // R7 synchronizer latency and disconnected masking (pin2 disconnected)
    pad_in = 32'h0000_0F04;
    @(negedge clk);
    rd_chk("R7 one flop not visible", 12'h510, 32'h0);
    rd_chk("R7 after two flops", 12'h510, 32'h0000_0F00);

    // R8 / R9 sensing
    pad_in = '0;
    repeat (3) @(negedge clk);
    do_wr(12'h720, 32'h0002_0000);
    chk("R9 no match", {31'd0, detect}, 32'd0);
    rd_chk("R8 nothing latched", 12'h520, 32'h0);
    pad_in[8] = 1'b1;
    @(negedge clk);
    chk("R9 live not yet", {31'd0, detect}, 32'd0);
    @(negedge clk);
    chk("R9 live match", {31'd0, detect}, 32'd1);
    repeat (2) @(negedge clk);
    pad_in[8] = 1'b0;
    repeat (3) @(negedge clk);
    chk("R9 live follows", {31'd0, detect}, 32'd0);
    rd_chk("R8 sticky", 12'h520, 32'h0000_0100);
    do_wr(12'h524, 32'h1);
    chk("R9 latched mode", {31'd0, detect}, 32'd1);
    rd_chk("R9 mode reads", 12'h524, 32'h1);
    do_wr(12'h520, 32'h0000_00FF);
    rd_chk("R8 zero no clear", 12'h520, 32'h0000_0100);
    do_wr(12'h520, 32'h0000_0100);
    rd_chk("R8 w1c", 12'h520, 32'h0);
    chk("R9 latched cleared", {31'd0, detect}, 32'd0);
    pad_in[8] = 1'b1;
    repeat (4) @(negedge clk);
    do_wr(12'h520, 32'h0000_0100);
    rd_chk("R8 persist beats clear", 12'h520, 32'h0000_0100);
    pad_in = '0;
    do_wr(12'h724, 32'h0003_0000);
    do_wr(12'h728, 32'h0001_0000);
    repeat (4) @(negedge clk);
    rd_chk("R8 low sense", 12'h520, 32'h0000_0300);
    do_wr(12'h520, 32'hFFFF_FFFF);
    @(negedge clk);
    rd_chk("R8 code1 never matches", 12'h520, 32'h0000_0200);
    chk("R9 latched high", {31'd0, detect}, 32'd1);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule